// File: doc/BRIEF.md
# Up/Down/Center-Aligned Timer Counter

A 16-bit timer counter with a programmable clock divider and a reload limit. The counter can run upward (wrapping from the limit back to zero), downward (wrapping from zero back to the limit), or in one of three center-aligned variants. The center-aligned variants sweep from zero up to the limit and back down to zero, and differ only in which sweep lets compare channels raise their flags. Each wrap of the counter (top or bottom) is a counter update, and it produces an update event unless events are switched off. The same update event refreshes the buffered reload limit and the divider value.

Software controls the block through a configuration write (run, direction, alignment, one-shot, reload buffering, event disable, event-source filter, interrupt enable) and through separate write strobes for the reload limit and the divider. A software update strobe and an external reinitialise strobe restart the counter and the divider. An update flag records pending events and drives an interrupt line. A count qualifier gates the divider input cycle by cycle. A phase output tells compare channels whether the current sweep may raise flags.

Top module: `updown_timer`

## Requirements
- R1: After reset the count is 0, the update pulse, flag and interrupt are 0, the counter is stopped, the reload limit is all ones and the divider value is 0.
- R2: With alignment code 0 and the direction bit 0, each divider tick adds 1 to the count. A tick at count equal to the limit sets the count to 0 and produces a one-cycle update pulse, and the flag rises in the same cycle as the new count.
- R3: With alignment code 0 and the direction bit 1, each tick subtracts 1. A tick at count 0 loads the limit and produces an update pulse, and the direction output reads 1.
- R4: With alignment codes 1, 2 or 3, the count rises from 0 to the limit and then falls back to 0. An update pulse is produced on reaching the limit and on reaching 0. The direction output reads 1 during the falling sweep.
- R5: The phase output reads 1 always for code 0 and code 3, only in the falling sweep for code 1, and only in the rising sweep for code 2.
- R6: With one-shot set, any update event clears the run bit, and a stopped counter holds its count.
- R7: With reload buffering off, a limit write takes effect at once. With it on, the write waits for the next update event.
- R8: The divider issues one tick per (divider value + 1) qualified clock cycles, and only while the count qualifier is 1. A new divider value is applied only at an update event.
- R9: While the event-disable bit is 1, no update pulse and no flag are produced, and the counter still wraps.
- R10: With the source-filter bit at 0, counter wraps and both strobes set the flag. With it at 1, only counter wraps set the flag; a strobe still produces the pulse.
- R11: The software and external strobes restart the divider and load the count with 0, or with the limit in downward edge mode. They also start the rising sweep and, when events are allowed, move the buffered limit and divider into use.
- R12: A flag-clear strobe clears the flag on the next edge, and a simultaneous flag set takes priority. The interrupt output is the flag qualified by the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads all configuration fields below |
| cfg_run | input | 1 | Run bit |
| cfg_down | input | 1 | Direction in edge mode (1 = downward) |
| cfg_align | input | 2 | Alignment code 0..3 |
| cfg_one_shot | input | 1 | Stop at next update event |
| cfg_buffered | input | 1 | Buffer reload writes until an update event |
| cfg_upd_off | input | 1 | Suppress update events |
| cfg_wrap_only | input | 1 | Only counter wraps set the flag |
| cfg_irq_en | input | 1 | Interrupt enable |
| reload_wr | input | 1 | Reload limit write strobe |
| reload_val | input | 16 | Reload limit data |
| presc_wr | input | 1 | Divider write strobe |
| presc_val | input | 16 | Divider data (divide by value + 1) |
| count_qual | input | 1 | Count qualifier for the divider |
| sw_update | input | 1 | Software update strobe |
| ext_reinit | input | 1 | External reinitialise strobe |
| flag_clr | input | 1 | Update flag clear strobe |
| count | output | 16 | Counter value |
| count_down | output | 1 | Current direction (1 = downward) |
| upd_pulse | output | 1 | One-cycle update event |
| upd_flag | output | 1 | Pending update flag |
| upd_irq | output | 1 | Update interrupt |
| cmp_phase_ok | output | 1 | Compare flags allowed in this sweep |
| running | output | 1 | Current run bit |

## Verification
The counting function is tried with upward and downward edge sweeps and with each of the three center variants on small limits. Reading the count, direction and phase at the turn points separates the variants from one another and exposes errors of one at the limit and at zero. Further runs use a buffered limit written mid-configuration and a divider written without an update. These show whether new values are applied immediately or at the event. One-shot runs, disabled events and the filtered source setting show whether the event, flag and run bit react to the correct causes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ALIGN_EDGE     = 2'd0,
        ALIGN_CTR_DN   = 2'd1,
        ALIGN_CTR_UP   = 2'd2,
        ALIGN_CTR_BOTH = 2'd3
    } align_e;

    typedef struct packed {
        logic   run;
        logic   down;
        align_e mode;
        logic   one_shot;
        logic   buffered;
        logic   upd_off;
        logic   wrap_only;
        logic   irq_en;
    } tmr_ctrl_t;

    // Which sweep of the count may raise compare flags
    function automatic logic phase_allows(align_e m, logic falling);
        case (m)
            ALIGN_EDGE:   return 1'b1;
            ALIGN_CTR_DN: return falling;
            ALIGN_CTR_UP: return ~falling;
            default:      return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          qual,
    input  logic          restart,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] acc_q;
    logic          at_end;

    assign at_end = (acc_q >= div);
    assign tick   = run & qual & ~restart & at_end;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            acc_q <= '0;
        end else if (run && qual) begin
            acc_q <= at_end ? '0 : acc_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart,
    input  align_e        mode,
    input  logic          down_sel,
    input  logic [CW-1:0] limit,
    input  logic [CW-1:0] restart_val,
    output logic [CW-1:0] cnt,
    output logic          falling,
    output logic          wrap
);
    logic [CW-1:0] cnt_q, cnt_n;
    logic          fall_q, fall_n;
    logic [CW:0]   up_n;

    assign up_n = {1'b0, cnt_q} + 1'b1;

    always_comb begin
        cnt_n  = cnt_q;
        fall_n = fall_q;
        wrap   = 1'b0;
        if (tick) begin
            if (mode == ALIGN_EDGE) begin
                fall_n = 1'b0;
                if (!down_sel) begin
                    if (cnt_q >= limit) begin
                        cnt_n = '0;
                        wrap  = 1'b1;
                    end else begin
                        cnt_n = up_n[CW-1:0];
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_n = limit;
                        wrap  = 1'b1;
                    end else begin
                        cnt_n = cnt_q - 1'b1;
                    end
                end
            end else if (!fall_q) begin
                if (up_n >= {1'b0, limit}) begin
                    cnt_n  = limit;
                    fall_n = 1'b1;
                    wrap   = 1'b1;
                end else begin
                    cnt_n = up_n[CW-1:0];
                end
            end else begin
                if (cnt_q <= CW'(1)) begin
                    cnt_n  = '0;
                    fall_n = 1'b0;
                    wrap   = 1'b1;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fall_q <= 1'b0;
        end else if (restart) begin
            cnt_q  <= restart_val;
            fall_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            fall_q <= fall_n;
        end
    end

    assign cnt     = cnt_q;
    assign falling = fall_q;
endmodule

// File: rtl/tmr_update_ctl.sv
module tmr_update_ctl
    import tmr_pkg::*;
#(
    parameter int            CW          = 16,
    parameter int            PW          = 16,
    parameter logic [CW-1:0] RELOAD_INIT = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  tmr_ctrl_t     cfg_in,
    input  logic          reload_wr,
    input  logic [CW-1:0] reload_val,
    input  logic          presc_wr,
    input  logic [PW-1:0] presc_val,
    input  logic          sw_upd,
    input  logic          ext_upd,
    input  logic          flag_clr,
    input  logic          wrap,
    output tmr_ctrl_t     ctrl,
    output logic [CW-1:0] limit,
    output logic [CW-1:0] restart_val,
    output logic [PW-1:0] div,
    output logic          restart,
    output logic          evt_q,
    output logic          flag_q
);
    tmr_ctrl_t     ctrl_q;
    logic [CW-1:0] lim_pre, lim_act;
    logic [PW-1:0] div_pre, div_act;
    logic          evt, flag_set;

    assign restart  = sw_upd | ext_upd;
    assign evt      = ~ctrl_q.upd_off & (wrap | restart);
    assign flag_set = evt & (~ctrl_q.wrap_only | wrap);

    assign restart_val = (ctrl_q.mode == ALIGN_EDGE && ctrl_q.down)
                         ? (evt ? lim_pre : lim_act) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= tmr_ctrl_t'('0);
            lim_pre <= RELOAD_INIT;
            lim_act <= RELOAD_INIT;
            div_pre <= '0;
            div_act <= '0;
            evt_q   <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (cfg_wr) begin
                ctrl_q <= cfg_in;
            end else if (evt && ctrl_q.one_shot) begin
                ctrl_q.run <= 1'b0;
            end

            if (reload_wr) begin
                lim_pre <= reload_val;
            end
            if (reload_wr && !ctrl_q.buffered) begin
                lim_act <= reload_val;
            end else if (evt) begin
                lim_act <= lim_pre;
            end

            if (presc_wr) begin
                div_pre <= presc_val;
            end
            if (evt) begin
                div_act <= div_pre;
            end

            evt_q <= evt;
            if (flag_set) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign ctrl  = ctrl_q;
    assign limit = lim_act;
    assign div   = div_act;
endmodule

// File: rtl/updown_timer.sv
module updown_timer
    import tmr_pkg::*;
#(
    parameter int               CNT_W       = 16,
    parameter int               PSC_W       = 16,
    parameter logic [CNT_W-1:0] RELOAD_INIT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_run,
    input  logic             cfg_down,
    input  logic [1:0]       cfg_align,
    input  logic             cfg_one_shot,
    input  logic             cfg_buffered,
    input  logic             cfg_upd_off,
    input  logic             cfg_wrap_only,
    input  logic             cfg_irq_en,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             presc_wr,
    input  logic [PSC_W-1:0] presc_val,
    input  logic             count_qual,
    input  logic             sw_update,
    input  logic             ext_reinit,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             count_down,
    output logic             upd_pulse,
    output logic             upd_flag,
    output logic             upd_irq,
    output logic             cmp_phase_ok,
    output logic             running
);
    tmr_ctrl_t        cfg_in, ctrl;
    logic [CNT_W-1:0] limit, restart_val;
    logic [PSC_W-1:0] div;
    logic             restart, tick, wrap, falling;

    assign cfg_in = '{run:       cfg_run,
                      down:      cfg_down,
                      mode:      align_e'(cfg_align),
                      one_shot:  cfg_one_shot,
                      buffered:  cfg_buffered,
                      upd_off:   cfg_upd_off,
                      wrap_only: cfg_wrap_only,
                      irq_en:    cfg_irq_en};

    tmr_update_ctl #(.CW(CNT_W), .PW(PSC_W), .RELOAD_INIT(RELOAD_INIT)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_in     (cfg_in),
        .reload_wr  (reload_wr),
        .reload_val (reload_val),
        .presc_wr   (presc_wr),
        .presc_val  (presc_val),
        .sw_upd     (sw_update),
        .ext_upd    (ext_reinit),
        .flag_clr   (flag_clr),
        .wrap       (wrap),
        .ctrl       (ctrl),
        .limit      (limit),
        .restart_val(restart_val),
        .div        (div),
        .restart    (restart),
        .evt_q      (upd_pulse),
        .flag_q     (upd_flag)
    );

    tmr_prescaler #(.PW(PSC_W)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.run),
        .qual   (count_qual),
        .restart(restart),
        .div    (div),
        .tick   (tick)
    );

    tmr_counter #(.CW(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .restart    (restart),
        .mode       (ctrl.mode),
        .down_sel   (ctrl.down),
        .limit      (limit),
        .restart_val(restart_val),
        .cnt        (count),
        .falling    (falling),
        .wrap       (wrap)
    );

    assign count_down   = (ctrl.mode == ALIGN_EDGE) ? ctrl.down : falling;
    assign cmp_phase_ok = phase_allows(ctrl.mode, falling);
    assign upd_irq      = upd_flag & ctrl.irq_en;
    assign running      = ctrl.run;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic          sw_update,
    input logic          ext_reinit,
    input logic          flag_clr,
    input logic          running,
    input logic          upd_pulse,
    input logic          upd_flag,
    input logic [CW-1:0] count,
    input logic          upd_off_q,
    input logic          one_shot_q
);
    // R9
    upd_off_silent_chk: assert property (@(posedge clk) disable iff (rst)
        upd_off_q |=> !upd_pulse);

    // R12
    flag_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(upd_flag) |-> upd_pulse);

    // R12
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flag_clr) && !upd_pulse) |-> !upd_flag);

    // R6
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(one_shot_q) && upd_pulse && !$past(cfg_wr)) |-> !running);

    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!running && !sw_update && !ext_reinit) |-> $stable(count));
endmodule

bind updown_timer tmr_checker #(.CW(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .sw_update (sw_update),
    .ext_reinit(ext_reinit),
    .flag_clr  (flag_clr),
    .running   (running),
    .upd_pulse (upd_pulse),
    .upd_flag  (upd_flag),
    .count     (count),
    .upd_off_q (ctrl.upd_off),
    .one_shot_q(ctrl.one_shot)
);

// File: tb/updown_timer_test.sv
`timescale 1ns/1ps
module updown_timer_test;

    localparam int S_CNT = 0, S_DIR = 1, S_PLS = 2, S_FLG = 3,
                   S_IRQ = 4, S_PHS = 5, S_RUN = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 0, cfg_run = 0, cfg_down = 0;
    logic [1:0]  cfg_align = 0;
    logic        cfg_one_shot = 0, cfg_buffered = 0, cfg_upd_off = 0;
    logic        cfg_wrap_only = 0, cfg_irq_en = 0;
    logic        reload_wr = 0, presc_wr = 0;
    logic [15:0] reload_val = 0, presc_val = 0;
    logic        count_qual = 1, sw_update = 0, ext_reinit = 0, flag_clr = 0;
    logic [15:0] count;
    logic        count_down, upd_pulse, upd_flag, upd_irq, cmp_phase_ok, running;

    int edges = 0;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int    at;
        int    sig;
        int    val;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    updown_timer uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_run(cfg_run),
        .cfg_down(cfg_down), .cfg_align(cfg_align),
        .cfg_one_shot(cfg_one_shot), .cfg_buffered(cfg_buffered),
        .cfg_upd_off(cfg_upd_off), .cfg_wrap_only(cfg_wrap_only),
        .cfg_irq_en(cfg_irq_en), .reload_wr(reload_wr),
        .reload_val(reload_val), .presc_wr(presc_wr), .presc_val(presc_val),
        .count_qual(count_qual), .sw_update(sw_update),
        .ext_reinit(ext_reinit), .flag_clr(flag_clr), .count(count),
        .count_down(count_down), .upd_pulse(upd_pulse), .upd_flag(upd_flag),
        .upd_irq(upd_irq), .cmp_phase_ok(cmp_phase_ok), .running(running)
    );

    function automatic int observe(int s);
        case (s)
            S_CNT:   return int'(count);
            S_DIR:   return int'(count_down);
            S_PLS:   return int'(upd_pulse);
            S_FLG:   return int'(upd_flag);
            S_IRQ:   return int'(upd_irq);
            S_PHS:   return int'(cmp_phase_ok);
            S_RUN:   return int'(running);
            default: return -1;
        endcase
    endfunction

    // Monitor: compares queued expectations as their cycle arrives
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= edges) begin
            exp_t it;
            int   act;
            it  = sbq.pop_front();
            act = observe(it.sig);
            n_run++;
            if (it.at != edges || act != it.val) begin
                n_fail++;
                $display("FAIL %s sig=%0d actual=%0d expected=%0d", it.tag, it.sig, act, it.val);
            end
        end
    end

    // Driver side: queue an expectation k edges ahead
    task automatic want(int k, int sig, int val, string tag);
        exp_t it;
        it.at = edges + k; it.sig = sig; it.val = val; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic wait_edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_cfg(logic r, logic d, logic [1:0] a, logic os,
                           logic bf, logic off, logic wo, logic ie);
        cfg_run = r; cfg_down = d; cfg_align = a; cfg_one_shot = os;
        cfg_buffered = bf; cfg_upd_off = off; cfg_wrap_only = wo; cfg_irq_en = ie;
        cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    endtask

    task automatic put_reload(int v);
        reload_val = 16'(v); reload_wr = 1; @(negedge clk); reload_wr = 0;
    endtask

    task automatic put_presc(int v);
        presc_val = 16'(v); presc_wr = 1; @(negedge clk); presc_wr = 0;
    endtask

    task automatic pulse_sw();
        sw_update = 1; @(negedge clk); sw_update = 0;
    endtask

    task automatic pulse_ext();
        ext_reinit = 1; @(negedge clk); ext_reinit = 0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1; @(negedge clk); flag_clr = 0;
    endtask

    // Stopped configuration, new limit, restart, flag cleared
    task automatic prep(logic d, logic [1:0] a, logic os, logic bf, int lim);
        put_cfg(0, d, a, os, bf, 0, 0, 0);
        put_reload(lim);
        pulse_sw();
        pulse_clr();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_edges(3);
        rst = 0;

        // R1 reset state
        want(1, S_CNT, 0, "R1"); want(1, S_PLS, 0, "R1");
        want(1, S_FLG, 0, "R1"); want(1, S_IRQ, 0, "R1");
        want(1, S_RUN, 0, "R1");
        wait_edges(2);

        // R2 / R7 (unbuffered limit applies at once) / R12 interrupt
        put_reload(3);
        put_cfg(1, 0, 2'd0, 0, 0, 0, 0, 1);
        want(1, S_CNT, 1, "R2"); want(3, S_CNT, 3, "R7");
        want(4, S_CNT, 0, "R2"); want(4, S_PLS, 1, "R2");
        want(4, S_FLG, 1, "R2"); want(4, S_IRQ, 1, "R12");
        want(5, S_CNT, 1, "R2"); want(5, S_PLS, 0, "R2");
        wait_edges(5);
        put_cfg(0, 0, 2'd0, 0, 0, 0, 0, 1);
        pulse_clr();
        want(1, S_FLG, 0, "R12"); want(1, S_IRQ, 0, "R12");
        wait_edges(1);

        // R3 downward edge mode
        prep(1, 2'd0, 0, 0, 3);
        want(1, S_CNT, 3, "R11");
        wait_edges(1);
        put_cfg(1, 1, 2'd0, 0, 0, 0, 0, 0);
        want(1, S_CNT, 2, "R3"); want(1, S_DIR, 1, "R3");
        want(3, S_CNT, 0, "R3");
        want(4, S_CNT, 3, "R3"); want(4, S_PLS, 1, "R3");
        wait_edges(4);

        // R4 / R5 center code 1
        prep(0, 2'd1, 0, 0, 3);
        put_cfg(1, 0, 2'd1, 0, 0, 0, 0, 0);
        want(1, S_CNT, 1, "R4"); want(1, S_DIR, 0, "R4"); want(1, S_PHS, 0, "R5");
        want(3, S_CNT, 3, "R4"); want(3, S_PLS, 1, "R4");
        want(3, S_DIR, 1, "R4"); want(3, S_PHS, 1, "R5");
        want(4, S_CNT, 2, "R4");
        want(6, S_CNT, 0, "R4"); want(6, S_PLS, 1, "R4"); want(6, S_DIR, 0, "R4");
        want(7, S_CNT, 1, "R4");
        wait_edges(7);

        // R5 center code 2
        prep(0, 2'd2, 0, 0, 3);
        put_cfg(1, 0, 2'd2, 0, 0, 0, 0, 0);
        want(1, S_PHS, 1, "R5");
        want(4, S_CNT, 2, "R4"); want(4, S_PHS, 0, "R5");
        wait_edges(4);

        // R5 center code 3
        prep(0, 2'd3, 0, 0, 3);
        put_cfg(1, 0, 2'd3, 0, 0, 0, 0, 0);
        want(1, S_PHS, 1, "R5"); want(4, S_PHS, 1, "R5");
        wait_edges(4);

        // R6 one-shot
        prep(0, 2'd0, 1, 0, 2);
        put_cfg(1, 0, 2'd0, 1, 0, 0, 0, 0);
        want(2, S_CNT, 2, "R6"); want(2, S_RUN, 1, "R6");
        want(3, S_CNT, 0, "R6"); want(3, S_PLS, 1, "R6"); want(3, S_RUN, 0, "R6");
        want(6, S_CNT, 0, "R6"); want(6, S_RUN, 0, "R6");
        wait_edges(6);

        // R9 events disabled
        prep(0, 2'd0, 0, 0, 2);
        put_cfg(1, 0, 2'd0, 0, 0, 1, 0, 0);
        want(3, S_CNT, 0, "R9"); want(3, S_PLS, 0, "R9"); want(3, S_FLG, 0, "R9");
        want(4, S_CNT, 1, "R9");
        wait_edges(4);
        // R11 strobe restarts count even with events off, still no flag
        want(1, S_CNT, 0, "R11"); want(1, S_PLS, 0, "R9"); want(1, S_FLG, 0, "R9");
        pulse_sw();

        // R10 source filtering
        put_cfg(0, 0, 2'd0, 0, 0, 0, 1, 0);
        want(1, S_PLS, 1, "R10"); want(1, S_FLG, 0, "R10");
        pulse_sw();
        put_cfg(0, 0, 2'd0, 0, 0, 0, 0, 0);
        want(1, S_FLG, 1, "R10");
        pulse_ext();
        prep(0, 2'd0, 0, 0, 2);
        put_cfg(1, 0, 2'd0, 0, 0, 0, 1, 0);
        want(3, S_PLS, 1, "R10"); want(3, S_FLG, 1, "R10");
        wait_edges(3);

        // R7 buffered limit waits for the update
        prep(0, 2'd0, 0, 1, 3);
        put_reload(5);
        put_cfg(1, 0, 2'd0, 0, 1, 0, 0, 0);
        want(3, S_CNT, 3, "R7");
        want(4, S_CNT, 0, "R7"); want(4, S_PLS, 1, "R7");
        want(9, S_CNT, 5, "R7");
        want(10, S_CNT, 0, "R7"); want(10, S_PLS, 1, "R7");
        wait_edges(10);

        // R8 divider applied at update only, qualifier gates ticks
        prep(0, 2'd0, 0, 0, 3);
        put_presc(1);
        put_cfg(1, 0, 2'd0, 0, 0, 0, 0, 0);
        want(1, S_CNT, 1, "R8");
        want(4, S_CNT, 0, "R8");
        want(5, S_CNT, 0, "R8");
        want(6, S_CNT, 1, "R8");
        want(8, S_CNT, 2, "R8");
        wait_edges(8);
        count_qual = 0;
        want(3, S_CNT, 2, "R8");
        wait_edges(3);
        count_qual = 1;

        wait_edges(3);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule